// File: doc/BRIEF.md
# Endian-Selectable Load/Store Lane Aligner

This block connects a 64-bit integer register datapath to a byte-addressed data memory that has a single 64-bit data port. On each request it adds a sign-extended 16-bit displacement to a base register value to form the byte address. Base index 0 always reads as zero, so that case gives absolute addressing. A zero displacement gives plain register-indirect access. It then works out which byte lanes an 8-, 16-, 32- or 64-bit access touches.

A per-request mode input picks the byte order. In little-endian mode, byte offset 0 sits in the least significant lane. In big-endian mode, it sits in the most significant lane. Stores leave with the element copied into every lane and a byte-enable mask marking the lanes to write. Memory answers a load one cycle after the request. The returned word is then shifted down, and the element is zero- or sign-extended to 64 bits before it goes to the register file.

An address that is not naturally aligned raises a flag and blocks the memory access. The block never splits such an access into parts. A load aimed at register 0 completes but writes nothing.

Top module: `lsAligner`

## Requirements
- R1: `memAddr` equals `baseVal` plus `disp` sign-extended to 64 bits (modulo 2^64). When `baseIdx` is 0, the base counts as zero whatever `baseVal` holds.
- R2: `reqSize` encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes. The byte offset is `memAddr[2:0]`, and lane k is `memWdata`/`memRdata` bits 8k+7..8k.
- R3: When `reqValid` is high and `memAddr[2:0]` is not a multiple of the access width, `misalign` is 1, `memRead`, `memWrite` and `memByteEn` are all 0, and no load result follows.
- R4: In little-endian mode (`bigEndian`=0), an aligned store of n bytes at offset o drives `memByteEn` with n ones starting at bit o.
- R5: In big-endian mode (`bigEndian`=1), an aligned store of n bytes at offset o drives `memByteEn` with n ones starting at bit 8-o-n, so offset 0 maps to lane 7.
- R6: For a store, lane L of `memWdata` carries byte (L mod n) of `storeVal`.
- R7: A load request with `memRead` high is followed in the next cycle by `loadValid`=1. `loadData` is then the element read from `memRdata` using the lane rule of R4 (little-endian) or R5 (big-endian).
- R8: When `reqSigned` is 0, a load is zero-extended to 64 bits. When it is 1, the load is sign-extended from the element's top bit.
- R9: A load whose `destIdx` is 0 gives `loadValid`=1 with `loadWe`=0 and `loadData`=0.
- R10: During and right after reset, `loadValid` is 0. While `reqValid` is 0, `memRead`, `memWrite`, `misalign` and `memByteEn` are 0.
- R11: The byte order, width, signedness and destination used for a load result are those present at the request cycle. Later changes to `bigEndian` do not affect that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A load or store request is present this cycle |
| reqStore | input | 1 | 1 for a store, 0 for a load |
| reqSize | input | 2 | Access width code (R2) |
| reqSigned | input | 1 | Sign-extend the load result |
| bigEndian | input | 1 | Byte-order mode: 1 big-endian, 0 little-endian |
| baseIdx | input | 5 | Index of the base register; 0 forces a zero base |
| baseVal | input | 64 | Value read from the base register |
| disp | input | 16 | Signed displacement |
| destIdx | input | 5 | Destination register of a load |
| storeVal | input | 64 | Register value to be stored |
| memRdata | input | 64 | Memory read word, valid the cycle after `memRead` |
| memAddr | output | 64 | Effective byte address |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| memByteEn | output | 8 | Lanes to write |
| memWdata | output | 64 | Replicated store data |
| misalign | output | 1 | Request is not naturally aligned |
| loadValid | output | 1 | Load result present |
| loadWe | output | 1 | Register-file write enable for the load |
| loadDest | output | 5 | Destination register of the load result |
| loadData | output | 64 | Aligned and extended load result |

## Verification
Stores are tried at every width, at offsets in the lower and upper half of the word, in both byte orders. This separates the little-endian mask position from the big-endian one, and the lane copying of each width from the others. Loads read a fixed word whose eight lanes all hold different, negative-topped bytes, so the value returned shows exactly which lanes were chosen, and comparing signed with unsigned reads shows the extension. A negative displacement and a zero base index check the address adder. Misaligned requests in both modes, a destination of 0, and a mode flip between request and return cover the remaining edges.

// File: rtl/lsAlignPkg.sv
package lsAlignPkg;
  localparam int XLEN   = 64;
  localparam int LANES  = XLEN / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    accSize_e          stSize;
    logic [LANE_W-1:0] ldShift;
    accSize_e          ldSize;
    logic              ldSigned;
    logic              ldKill;
  } dpStrobes_t;
endpackage

// File: rtl/lsAlignDatapath.sv
module lsAlignDatapath
  import lsAlignPkg::*;
#(
  parameter int DISP_W = 16,
  parameter int REG_W  = 5
) (
  input  logic [REG_W-1:0]  baseIdx,
  input  logic [XLEN-1:0]   baseVal,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   storeVal,
  input  logic [XLEN-1:0]   memRdata,
  input  dpStrobes_t        strobes,
  output logic [XLEN-1:0]   effAddr,
  output logic [XLEN-1:0]   memWdata,
  output logic [XLEN-1:0]   loadData
);
  logic [XLEN-1:0] baseEff;
  logic [XLEN-1:0] dispExt;
  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] extended;

  // address generation
  always_comb begin
    baseEff = (baseIdx == '0) ? '0 : baseVal;
    dispExt = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
    effAddr = baseEff + dispExt;
  end

  // store lane replication: lane L takes element byte (L mod width)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int HALF_SRC = l % 2;
    localparam int WORD_SRC = l % 4;
    always_comb begin
      unique case (strobes.stSize)
        SZ_BYTE:  memWdata[8*l +: 8] = storeVal[7:0];
        SZ_HALF:  memWdata[8*l +: 8] = storeVal[8*HALF_SRC +: 8];
        SZ_WORD:  memWdata[8*l +: 8] = storeVal[8*WORD_SRC +: 8];
        default:  memWdata[8*l +: 8] = storeVal[8*l +: 8];
      endcase
    end
  end

  // load lane extraction and extension
  always_comb begin
    shifted = memRdata >> {strobes.ldShift, 3'b000};
    unique case (strobes.ldSize)
      SZ_BYTE:  extended = {{(XLEN-8){strobes.ldSigned & shifted[7]}}, shifted[7:0]};
      SZ_HALF:  extended = {{(XLEN-16){strobes.ldSigned & shifted[15]}}, shifted[15:0]};
      SZ_WORD:  extended = {{(XLEN-32){strobes.ldSigned & shifted[31]}}, shifted[31:0]};
      default:  extended = shifted;
    endcase
    loadData = strobes.ldKill ? '0 : extended;
  end
endmodule

// File: rtl/lsAlignCtrl.sv
module lsAlignCtrl
  import lsAlignPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic              bigEndian,
  input  logic [LANE_W-1:0] addrLow,
  input  logic [REG_W-1:0]  destIdx,
  output logic              memRead,
  output logic              memWrite,
  output logic              misalign,
  output logic [LANES-1:0]  memByteEn,
  output dpStrobes_t        strobes,
  output logic              loadValid,
  output logic              loadWe,
  output logic [REG_W-1:0]  loadDest
);
  logic [LANE_W:0]   sizeBytes;
  logic [LANE_W:0]   beShiftWide;
  logic [LANE_W-1:0] laneShift;
  logic [LANES-1:0]  baseMask;
  logic              offBad;

  logic              pendValid;
  logic [LANE_W-1:0] pendShift;
  accSize_e          pendSize;
  logic              pendSigned;
  logic [REG_W-1:0]  pendDest;

  always_comb begin
    sizeBytes   = (LANE_W+1)'(1) << reqSize;
    offBad      = |(addrLow & LANE_W'(sizeBytes - (LANE_W+1)'(1)));
    beShiftWide = (LANE_W+1)'(LANES) - {1'b0, addrLow} - sizeBytes;
    laneShift   = bigEndian ? beShiftWide[LANE_W-1:0] : addrLow;
    baseMask    = LANES'((32'd1 << sizeBytes) - 32'd1);
    misalign    = reqValid & offBad;
    memRead     = reqValid & ~reqStore & ~offBad;
    memWrite    = reqValid & reqStore & ~offBad;
    memByteEn   = memWrite ? (baseMask << laneShift) : '0;
  end

  // load context held for the return cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid  <= 1'b0;
      pendShift  <= '0;
      pendSize   <= SZ_BYTE;
      pendSigned <= 1'b0;
      pendDest   <= '0;
    end else begin
      pendValid <= memRead;
      if (memRead) begin
        pendShift  <= laneShift;
        pendSize   <= accSize_e'(reqSize);
        pendSigned <= reqSigned;
        pendDest   <= destIdx;
      end
    end
  end

  always_comb begin
    strobes.stSize   = accSize_e'(reqSize);
    strobes.ldShift  = pendShift;
    strobes.ldSize   = pendSize;
    strobes.ldSigned = pendSigned;
    strobes.ldKill   = (pendDest == '0);
    loadValid        = pendValid;
    loadWe           = pendValid & (pendDest != '0);
    loadDest         = pendDest;
  end
endmodule

// File: rtl/lsAligner.sv
module lsAligner
  import lsAlignPkg::*;
#(
  parameter int DISP_W = 16,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic              bigEndian,
  input  logic [REG_W-1:0]  baseIdx,
  input  logic [XLEN-1:0]   baseVal,
  input  logic [DISP_W-1:0] disp,
  input  logic [REG_W-1:0]  destIdx,
  input  logic [XLEN-1:0]   storeVal,
  input  logic [XLEN-1:0]   memRdata,
  output logic [XLEN-1:0]   memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [LANES-1:0]  memByteEn,
  output logic [XLEN-1:0]   memWdata,
  output logic              misalign,
  output logic              loadValid,
  output logic              loadWe,
  output logic [REG_W-1:0]  loadDest,
  output logic [XLEN-1:0]   loadData
);
  dpStrobes_t strobes;

  lsAlignDatapath #(.DISP_W(DISP_W), .REG_W(REG_W)) u_dp (
    .baseIdx  (baseIdx),
    .baseVal  (baseVal),
    .disp     (disp),
    .storeVal (storeVal),
    .memRdata (memRdata),
    .strobes  (strobes),
    .effAddr  (memAddr),
    .memWdata (memWdata),
    .loadData (loadData)
  );

  lsAlignCtrl #(.REG_W(REG_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqStore  (reqStore),
    .reqSize   (reqSize),
    .reqSigned (reqSigned),
    .bigEndian (bigEndian),
    .addrLow   (memAddr[LANE_W-1:0]),
    .destIdx   (destIdx),
    .memRead   (memRead),
    .memWrite  (memWrite),
    .misalign  (misalign),
    .memByteEn (memByteEn),
    .strobes   (strobes),
    .loadValid (loadValid),
    .loadWe    (loadWe),
    .loadDest  (loadDest)
  );
endmodule

// File: rtl/lsAlignChecker.sv
module lsAlignChecker
  import lsAlignPkg::*;
#(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       reqSize,
  input logic             memRead,
  input logic             memWrite,
  input logic [LANES-1:0] memByteEn,
  input logic             misalign,
  input logic             loadValid,
  input logic             loadWe,
  input logic [REG_W-1:0] loadDest
);
  // R3
  misalign_blocks_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (!memRead && !memWrite && memByteEn == '0));

  // R4
  write_lane_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> ($countones(memByteEn) == (32'd1 << reqSize)));

  // R7
  read_then_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRead |=> loadValid);

  // R7
  load_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(memRead));

  // R9
  r0_load_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && loadDest == '0) |-> !loadWe);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!memRead && !memWrite && !misalign && memByteEn == '0));
endmodule

bind lsAligner lsAlignChecker #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqSize   (reqSize),
  .memRead   (memRead),
  .memWrite  (memWrite),
  .memByteEn (memByteEn),
  .misalign  (misalign),
  .loadValid (loadValid),
  .loadWe    (loadWe),
  .loadDest  (loadDest)
);

// File: tb/lsAligner_tb.sv
module lsAligner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  localparam logic [63:0] ST_VAL = 64'h1122334455667788;
  localparam logic [63:0] MEM_WORD = 64'h8899AABBCCDDEEFF;

  typedef struct packed {
    logic        isSt;
    logic [1:0]  sz;
    logic        sgn;
    logic        be;
    logic [63:0] base;
    logic [15:0] disp;
    logic [63:0] expAddr;
    logic        expMis;
    logic [7:0]  expEn;
    logic [63:0] expData;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, 1'b0, 1'b0, 64'h1000, 16'h0003, 64'h1003, 1'b0, 8'h08, 64'h8888888888888888},
    '{1'b1, 2'd0, 1'b0, 1'b1, 64'h1000, 16'h0003, 64'h1003, 1'b0, 8'h10, 64'h8888888888888888},
    '{1'b1, 2'd1, 1'b0, 1'b0, 64'h2000, 16'hFFFE, 64'h1FFE, 1'b0, 8'hC0, 64'h7788778877887788},
    '{1'b1, 2'd1, 1'b0, 1'b1, 64'h2000, 16'hFFFE, 64'h1FFE, 1'b0, 8'h03, 64'h7788778877887788},
    '{1'b1, 2'd2, 1'b0, 1'b1, 64'h0100, 16'h0004, 64'h0104, 1'b0, 8'h0F, 64'h5566778855667788},
    '{1'b1, 2'd3, 1'b0, 1'b0, 64'h0008, 16'h0000, 64'h0008, 1'b0, 8'hFF, 64'h1122334455667788},
    '{1'b1, 2'd2, 1'b0, 1'b0, 64'h0100, 16'h0002, 64'h0102, 1'b1, 8'h00, 64'h0},
    '{1'b1, 2'd1, 1'b0, 1'b1, 64'h1000, 16'h0001, 64'h1001, 1'b1, 8'h00, 64'h0},
    '{1'b0, 2'd0, 1'b0, 1'b0, 64'h0005, 16'h0000, 64'h0005, 1'b0, 8'h00, 64'h00000000000000AA},
    '{1'b0, 2'd0, 1'b1, 1'b0, 64'h0005, 16'h0000, 64'h0005, 1'b0, 8'h00, 64'hFFFFFFFFFFFFFFAA},
    '{1'b0, 2'd0, 1'b1, 1'b1, 64'h0005, 16'h0000, 64'h0005, 1'b0, 8'h00, 64'hFFFFFFFFFFFFFFDD},
    '{1'b0, 2'd1, 1'b0, 1'b1, 64'h0010, 16'h0002, 64'h0012, 1'b0, 8'h00, 64'h000000000000AABB},
    '{1'b0, 2'd1, 1'b1, 1'b0, 64'h0010, 16'h0002, 64'h0012, 1'b0, 8'h00, 64'hFFFFFFFFFFFFCCDD},
    '{1'b0, 2'd2, 1'b1, 1'b0, 64'h0020, 16'h0000, 64'h0020, 1'b0, 8'h00, 64'hFFFFFFFFCCDDEEFF},
    '{1'b0, 2'd2, 1'b0, 1'b1, 64'h0020, 16'h0000, 64'h0020, 1'b0, 8'h00, 64'h000000008899AABB},
    '{1'b0, 2'd2, 1'b1, 1'b1, 64'h0020, 16'h0004, 64'h0024, 1'b0, 8'h00, 64'hFFFFFFFFCCDDEEFF},
    '{1'b0, 2'd3, 1'b0, 1'b1, 64'h0040, 16'h0000, 64'h0040, 1'b0, 8'h00, 64'h8899AABBCCDDEEFF},
    '{1'b0, 2'd2, 1'b0, 1'b0, 64'h0020, 16'h0005, 64'h0025, 1'b1, 8'h00, 64'h0}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqStore, reqSigned, bigEndian;
  logic [1:0]  reqSize;
  logic [4:0]  baseIdx, destIdx;
  logic [63:0] baseVal, storeVal, memRdata;
  logic [15:0] disp;
  logic [63:0] memAddr, memWdata, loadData;
  logic        memRead, memWrite, misalign, loadValid, loadWe;
  logic [7:0]  memByteEn;
  logic [4:0]  loadDest;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsAligner u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqSize(reqSize), .reqSigned(reqSigned), .bigEndian(bigEndian),
    .baseIdx(baseIdx), .baseVal(baseVal), .disp(disp), .destIdx(destIdx),
    .storeVal(storeVal), .memRdata(memRdata), .memAddr(memAddr),
    .memRead(memRead), .memWrite(memWrite), .memByteEn(memByteEn),
    .memWdata(memWdata), .misalign(misalign), .loadValid(loadValid),
    .loadWe(loadWe), .loadDest(loadDest), .loadData(loadData)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqStore = 1'b0; reqSize = 2'd0;
    reqSigned = 1'b0; bigEndian = 1'b0; baseIdx = 5'd3; destIdx = 5'd7;
    baseVal = '0; disp = '0; storeVal = ST_VAL; memRdata = MEM_WORD;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 loadValid in reset", 64'(loadValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R10 loadValid after reset", 64'(loadValid), 64'd0);
    chk("R10 memRead idle", 64'(memRead), 64'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      reqValid = 1'b1; reqStore = VECS[i].isSt; reqSize = VECS[i].sz;
      reqSigned = VECS[i].sgn; bigEndian = VECS[i].be;
      baseVal = VECS[i].base; disp = VECS[i].disp;
      #1;
      chk("R1 address", memAddr, VECS[i].expAddr);
      chk("R3 misalign flag", 64'(misalign), 64'(VECS[i].expMis));
      if (VECS[i].isSt) begin
        chk("R3 memWrite", 64'(memWrite), 64'(!VECS[i].expMis));
        chk("R4 R5 byte enables", 64'(memByteEn), 64'(VECS[i].expEn));
        if (!VECS[i].expMis) chk("R6 store lanes", memWdata, VECS[i].expData);
      end else begin
        chk("R3 memRead", 64'(memRead), 64'(!VECS[i].expMis));
        chk("R10 no enables on load", 64'(memByteEn), 64'd0);
      end
      @(negedge clk);
      reqValid = 1'b0;
      #1;
      if (!VECS[i].isSt) begin
        chk("R7 loadValid", 64'(loadValid), 64'(!VECS[i].expMis));
        if (!VECS[i].expMis) begin
          chk("R7 R8 load data", loadData, VECS[i].expData);
          chk("R9 loadWe nonzero dest", 64'(loadWe), 64'd1);
        end
      end else begin
        chk("R7 no load after store", 64'(loadValid), 64'd0);
      end
    end

    // R1 zero base index, negative displacement
    @(negedge clk);
    reqValid = 1'b1; reqStore = 1'b0; reqSize = 2'd0; baseIdx = 5'd0;
    baseVal = 64'hDEADBEEF00000000; disp = 16'h8000;
    #1;
    chk("R1 zero base", memAddr, 64'hFFFFFFFFFFFF8000);
    baseIdx = 5'd3;

    // R9 load to register 0
    @(negedge clk);
    reqValid = 1'b1; reqStore = 1'b0; reqSize = 2'd3; reqSigned = 1'b0;
    bigEndian = 1'b0; baseVal = 64'h40; disp = '0; destIdx = 5'd0;
    @(negedge clk);
    reqValid = 1'b0; #1;
    chk("R9 loadValid", 64'(loadValid), 64'd1);
    chk("R9 loadWe", 64'(loadWe), 64'd0);
    chk("R9 loadData", loadData, 64'd0);
    destIdx = 5'd7;

    // R11 mode captured at request
    @(negedge clk);
    reqValid = 1'b1; reqSize = 2'd2; reqSigned = 1'b0; bigEndian = 1'b1;
    baseVal = 64'h20; disp = '0;
    @(negedge clk);
    reqValid = 1'b0; bigEndian = 1'b0; reqSigned = 1'b1; #1;
    chk("R11 captured byte order", loadData, 64'h000000008899AABB);
    chk("R11 captured dest", 64'(loadDest), 64'd7);

    // R10 idle store inputs do nothing
    @(negedge clk);
    reqValid = 1'b0; reqStore = 1'b1; reqSize = 2'd3; #1;
    chk("R10 idle memWrite", 64'(memWrite), 64'd0);
    chk("R10 idle byte enables", 64'(memByteEn), 64'd0);

    done = 1'b1;
    finishRun();
  end
endmodule